// File: doc/BRIEF.md
# Read Burst Output Window Tracker

This block follows, from the controller side, the window in which a double-data-rate memory device drives read data back onto the shared data bus. It accepts one command per clock (no-op, read or precharge) with a bank address. From these it produces, for every clock, a valid flag for the rising-edge half and one for the falling-edge half, the burst word index carried in each half, and an enable that says when the bus is driven rather than left high-impedance.

A read starts a burst whose first word pair appears a CAS latency after the command. Two words are delivered per clock until the configured burst length is reached. A precharge to the bank that is being read, issued while the burst is still under way, cuts the window short: data stays valid until CAS latency minus one clock after the precharge, and the bus is released after that. The CAS latency and burst length are sampled when the read is accepted. They are ignored while a burst is being tracked.

Top module: `rd_window_tracker`

## Requirements
- R1: During and directly after a synchronous active-high reset, both valid flags and the bus enable are low and both word indices are zero.
- R2: The command is encoded as 0 = no-op, 1 = read, 2 = precharge, 3 = treated as no-op. A read sampled at edge T while idle makes the first word pair visible after edge T+CL. CL is 2 when `cfg_cas_lat` is 2 and 3 for any other value.
- R3: `cfg_burst_code` selects the burst length: 0 gives 2 words, 1 gives 4, and 2 or 3 gives 8. Without truncation, both valid flags stay high for exactly length/2 consecutive clocks.
- R4: In the k-th data clock of a burst (k from 0), the rising-half index is 2k and the falling-half index is 2k+1. Both indices are zero whenever data is not valid.
- R5: The bus enable rises one clock before the first data clock, stays high through the last data clock, and is low in the clock after the last data clock.
- R6: A precharge to the bank of the tracked read, sampled at edge P (at least one clock after the read), keeps data valid no later than the cycle after edge P+CL-1. Valid and the bus enable are low from edge P+CL.
- R7: A precharge to the tracked bank sampled CL or fewer clocks before the natural end of the burst leaves every word delivered.
- R8: A precharge to any other bank has no effect on the burst in progress.
- R9: A read sampled while a burst is being tracked is ignored. Configuration changes after the read edge do not alter the burst in progress.
- R10: Only the first matching precharge of a burst sets the cut-off. Later ones neither extend nor shorten it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | Command code: 0 no-op, 1 read, 2 precharge, 3 no-op |
| cmd_bank | input | BANK_W | Bank address of the command |
| cfg_cas_lat | input | 2 | CAS latency select, sampled with a read |
| cfg_burst_code | input | 2 | Burst length select, sampled with a read |
| dq_valid_rise | output | 1 | Word valid in the rising-edge half of the clock |
| dq_valid_fall | output | 1 | Word valid in the falling-edge half of the clock |
| word_idx_rise | output | 3 | Burst index of the rising-half word |
| word_idx_fall | output | 3 | Burst index of the falling-half word |
| bus_drive | output | 1 | Data bus driven (low means high-impedance) |

## Verification
The properties assume that commands arrive as legal single-cycle codes. They also assume that an interrupting precharge follows its read by at least one clock, which the encoding guarantees because only one command exists per edge. Under these assumptions no burst exceeds four data clocks and every window opens with a preamble clock. The stimulus builds each scenario around one accepted read and places precharges, stray reads and reserved codes only at later edges. Extra reads are restricted to the edges where the tracker is still busy, so the expected window stays well defined. The configuration inputs are randomised on every edge after the read.

// File: rtl/rwt_pkg.sv
package rwt_pkg;

    localparam int MAX_BURST = 8;
    localparam int BEAT_W    = $clog2(MAX_BURST / 2);
    localparam int IDX_W     = BEAT_W + 1;
    localparam int LAT_W     = 2;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_READ = 2'd1,
        CMD_PRE  = 2'd2,
        CMD_RSVD = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DATA = 2'd2
    } phase_e;

    typedef struct packed {
        logic [LAT_W-1:0]  cas_lat;
        logic [BEAT_W-1:0] last_beat;
    } burst_ctx_s;

    // latency in clocks: 2 for code 2, otherwise 3
    function automatic logic [LAT_W-1:0] cl_decode(input logic [1:0] code);
        return (code == 2'd2) ? LAT_W'(2) : LAT_W'(3);
    endfunction

    // index of the final two-word beat of a burst
    function automatic logic [BEAT_W-1:0] last_beat_decode(input logic [1:0] code);
        case (code)
            2'd0:    return BEAT_W'(0);
            2'd1:    return BEAT_W'(1);
            default: return BEAT_W'((MAX_BURST / 2) - 1);
        endcase
    endfunction

endpackage

// File: rtl/rwt_dncnt.sv
module rwt_dncnt #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt  = cnt_q;
    assign zero = (cnt_q == '0);
endmodule

// File: rtl/rwt_cut_timer.sv
module rwt_cut_timer #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         arm,
    input  logic [W-1:0] delay,
    output logic         armed,
    output logic         expire
);
    logic         armed_q;
    logic [W-1:0] left;
    logic         left_zero;

    rwt_dncnt #(.W(W)) u_left (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear),
        .load     (arm),
        .load_val (delay),
        .cnt      (left),
        .zero     (left_zero)
    );

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            armed_q <= 1'b0;
        end else if (arm) begin
            armed_q <= 1'b1;
        end
    end

    assign armed  = armed_q;
    assign expire = armed_q && left_zero;
endmodule

// File: rtl/rwt_beat_ctr.sv
module rwt_beat_ctr
    import rwt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BEAT_W-1:0] last_in,
    input  logic              advance,
    output logic [BEAT_W-1:0] beat,
    output logic              is_last
);
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
            last_q <= '0;
        end else if (start) begin
            beat_q <= '0;
            last_q <= last_in;
        end else if (advance) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    assign beat    = beat_q;
    assign is_last = (beat_q == last_q);
endmodule

// File: rtl/rd_window_tracker.sv
module rd_window_tracker
    import rwt_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cmd,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [1:0]        cfg_cas_lat,
    input  logic [1:0]        cfg_burst_code,
    output logic              dq_valid_rise,
    output logic              dq_valid_fall,
    output logic [IDX_W-1:0]  word_idx_rise,
    output logic [IDX_W-1:0]  word_idx_fall,
    output logic              bus_drive
);
    cmd_e              cmd_c;
    phase_e            phase_q, phase_d;
    logic [BANK_W-1:0] bank_q;
    burst_ctx_s        ctx_q, ctx_new;

    logic              read_go, pre_hit, burst_end, in_data;
    logic              lat_zero;
    logic [LAT_W-1:0]  lat_cnt;
    logic              cut_armed, cut_expire;
    logic [BEAT_W-1:0] beat;
    logic              beat_last;

    assign cmd_c   = cmd_e'(cmd);
    assign in_data = (phase_q == ST_DATA);

    assign ctx_new.cas_lat   = cl_decode(cfg_cas_lat);
    assign ctx_new.last_beat = last_beat_decode(cfg_burst_code);

    assign read_go = (phase_q == ST_IDLE) && (cmd_c == CMD_READ);
    assign pre_hit = (phase_q != ST_IDLE) && (cmd_c == CMD_PRE)
                     && (cmd_bank == bank_q);
    assign burst_end = in_data && (cut_expire || beat_last);

    // read-to-data latency
    rwt_dncnt #(.W(LAT_W)) u_lat (
        .clk      (clk),
        .rst      (rst),
        .clear    (1'b0),
        .load     (read_go),
        .load_val (ctx_new.cas_lat - 1'b1),
        .cnt      (lat_cnt),
        .zero     (lat_zero)
    );

    // precharge cut-off deadline, first matching precharge only
    rwt_cut_timer #(.W(LAT_W)) u_cut (
        .clk    (clk),
        .rst    (rst),
        .clear  (burst_end),
        .arm    (pre_hit && !cut_armed),
        .delay  (ctx_q.cas_lat - 1'b1),
        .armed  (cut_armed),
        .expire (cut_expire)
    );

    rwt_beat_ctr u_beat (
        .clk     (clk),
        .rst     (rst),
        .start   (read_go),
        .last_in (ctx_new.last_beat),
        .advance (in_data && !burst_end),
        .beat    (beat),
        .is_last (beat_last)
    );

    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            ST_IDLE: if (read_go)   phase_d = ST_WAIT;
            ST_WAIT: if (lat_zero)  phase_d = ST_DATA;
            ST_DATA: if (burst_end) phase_d = ST_IDLE;
            default:                phase_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= ST_IDLE;
            bank_q  <= '0;
            ctx_q   <= '0;
        end else begin
            phase_q <= phase_d;
            if (read_go) begin
                bank_q <= cmd_bank;
                ctx_q  <= ctx_new;
            end
        end
    end

    assign dq_valid_rise = in_data;
    assign dq_valid_fall = in_data;
    assign word_idx_rise = in_data ? {beat, 1'b0} : '0;
    assign word_idx_fall = in_data ? {beat, 1'b1} : '0;
    assign bus_drive     = in_data || ((phase_q == ST_WAIT) && lat_zero);

endmodule

// File: rtl/rwt_checker.sv
module rwt_checker
    import rwt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             dq_valid_rise,
    input logic [IDX_W-1:0] word_idx_rise,
    input logic             bus_drive
);
    localparam int RUN_W = $clog2(MAX_BURST) + 1;

    logic [RUN_W-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst || !dq_valid_rise) begin
            run_len <= '0;
        end else if (run_len != '1) begin
            run_len <= run_len + 1'b1;
        end
    end

    AST_BURST_BEATS_MAX: assert property (@(posedge clk) disable iff (rst)
        dq_valid_rise |-> (run_len < RUN_W'(MAX_BURST / 2))); // R3

    AST_FIRST_WORD_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_valid_rise) |-> (word_idx_rise == '0)); // R4

    AST_WORD_STEP: assert property (@(posedge clk) disable iff (rst)
        (dq_valid_rise && $past(dq_valid_rise))
            |-> (word_idx_rise == ($past(word_idx_rise) + IDX_W'(2)))); // R4

    AST_PREAMBLE_DRIVE: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_valid_rise) |-> $past(bus_drive)); // R5

    AST_HIZ_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        $fell(dq_valid_rise) |-> !bus_drive); // R5

endmodule

bind rd_window_tracker rwt_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .dq_valid_rise (dq_valid_rise),
    .word_idx_rise (word_idx_rise),
    .bus_drive     (bus_drive)
);

// File: tb/tb_rd_window_tracker.sv
`timescale 1ns/1ps
module tb_rd_window_tracker;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cmd = 2'd0;
    logic [1:0] cmd_bank = 2'd0;
    logic [1:0] cfg_cas_lat = 2'd0;
    logic [1:0] cfg_burst_code = 2'd0;
    logic       dq_valid_rise, dq_valid_fall, bus_drive;
    logic [2:0] word_idx_rise, word_idx_fall;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    rd_window_tracker #(.BANK_W(2)) dut (
        .clk            (clk),
        .rst            (rst),
        .cmd            (cmd),
        .cmd_bank       (cmd_bank),
        .cfg_cas_lat    (cfg_cas_lat),
        .cfg_burst_code (cfg_burst_code),
        .dq_valid_rise  (dq_valid_rise),
        .dq_valid_fall  (dq_valid_fall),
        .word_idx_rise  (word_idx_rise),
        .word_idx_fall  (word_idx_fall),
        .bus_drive      (bus_drive)
    );

    task automatic cmp(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // expected outputs for the cycle after relative edge j
    task automatic check_cycle(input int j, input int cl, input int last, input string tag);
        bit e_v, e_d;
        int e_ir, e_if;
        e_v  = (j >= cl) && (j <= last);
        e_d  = (j >= cl - 1) && (j <= last);
        e_ir = e_v ? 2 * (j - cl) : 0;
        e_if = e_v ? e_ir + 1 : 0;
        cmp(tag, "valid_rise", int'(dq_valid_rise), int'(e_v));
        cmp(tag, "valid_fall", int'(dq_valid_fall), int'(e_v));
        cmp("R4", "idx_rise", int'(word_idx_rise), e_ir);
        cmp("R4", "idx_fall", int'(word_idx_fall), e_if);
        cmp("R5", "bus_drive", int'(bus_drive), int'(e_d));
    endtask

    task automatic run_case(input logic [1:0] clc, input logic [1:0] blc,
                            input int pre_k, input bit pre_same, input int pre2_k,
                            input int rd_k, input int junk_k, input string tag);
        logic [1:0] cmds [16];
        logic [1:0] banks [16];
        logic [1:0] bank;
        int cl, beats, last, n;
        bank  = 2'($urandom % 4);
        cl    = (clc == 2'd2) ? 2 : 3;
        beats = (blc == 2'd0) ? 1 : (blc == 2'd1) ? 2 : 4;
        last  = cl + beats - 1;
        for (int i = 0; i < 16; i++) begin
            cmds[i]  = 2'd0;
            banks[i] = 2'($urandom % 4);
        end
        cmds[0]  = 2'd1;
        banks[0] = bank;
        if (pre_k >= 1 && pre_k < 16) begin
            cmds[pre_k]  = 2'd2;
            banks[pre_k] = pre_same ? bank : (bank ^ 2'd1);
            if (pre_same && pre_k <= last && pre_k + cl - 1 < last) last = pre_k + cl - 1;
        end
        if (pre2_k >= 1 && pre2_k < 16 && cmds[pre2_k] == 2'd0) begin
            cmds[pre2_k]  = 2'd2;
            banks[pre2_k] = bank;
            if (pre2_k <= last && pre2_k + cl - 1 < last) last = pre2_k + cl - 1;
        end
        if (rd_k >= 1 && rd_k <= last && cmds[rd_k] == 2'd0) cmds[rd_k] = 2'd1;
        if (junk_k >= 1 && junk_k < 16 && cmds[junk_k] == 2'd0) cmds[junk_k] = 2'd3;
        n = last + 3;
        for (int k = 0; k <= n; k++) begin
            @(negedge clk);
            if (k >= 1) check_cycle(k - 1, cl, last, tag);
            cmd      = cmds[k];
            cmd_bank = banks[k];
            if (k == 0) begin
                cfg_cas_lat    = clc;
                cfg_burst_code = blc;
            end else begin
                cfg_cas_lat    = 2'($urandom % 4);
                cfg_burst_code = 2'($urandom % 4);
            end
        end
        @(negedge clk);
        check_cycle(n, cl, last, tag);
        cmd = 2'd0;
    endtask

    initial begin
        void'($urandom(32'h5eed_0a17));
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp("R1", "valid_rise in reset", int'(dq_valid_rise), 0);
        cmp("R1", "bus_drive in reset", int'(bus_drive), 0);
        cmp("R1", "idx_fall in reset", int'(word_idx_fall), 0);
        rst = 1'b0;
        @(negedge clk);
        cmp("R1", "valid_fall after reset", int'(dq_valid_fall), 0);
        cmp("R1", "idx_rise after reset", int'(word_idx_rise), 0);

        // directed corner cases
        run_case(2'd2, 2'd2, -1, 0, -1, -1, -1, "R2");
        run_case(2'd3, 2'd2, -1, 0, -1, -1, 2, "R2");
        run_case(2'd0, 2'd0, -1, 0, -1, -1, -1, "R3");
        run_case(2'd2, 2'd1, -1, 0, -1, -1, -1, "R3");
        run_case(2'd1, 2'd3, -1, 0, -1, -1, -1, "R3");
        run_case(2'd3, 2'd2, 1, 1, -1, -1, -1, "R6");
        run_case(2'd2, 2'd2, 1, 1, -1, -1, -1, "R6");
        run_case(2'd3, 2'd2, 2, 1, -1, -1, -1, "R6");
        run_case(2'd3, 2'd2, 4, 1, -1, -1, -1, "R7");
        run_case(2'd2, 2'd1, 2, 1, -1, -1, -1, "R7");
        run_case(2'd3, 2'd2, 1, 0, -1, -1, -1, "R8");
        run_case(2'd3, 2'd2, -1, 0, -1, 2, -1, "R9");
        run_case(2'd2, 2'd2, -1, 0, -1, 4, -1, "R9");
        run_case(2'd3, 2'd2, 2, 1, 3, -1, -1, "R10");
        run_case(2'd2, 2'd2, 1, 1, 2, -1, -1, "R10");

        // constrained random mix
        for (int s = 0; s < 400; s++) begin
            logic [1:0] clc, blc;
            int mode, pk, p2, rk, jk;
            clc  = 2'($urandom % 4);
            blc  = 2'($urandom % 4);
            mode = $urandom % 3;
            pk   = (mode == 0) ? -1 : 1 + int'($urandom % 8);
            p2   = ($urandom % 4 == 0) ? 1 + int'($urandom % 8) : -1;
            rk   = ($urandom % 3 == 0) ? 1 + int'($urandom % 6) : -1;
            jk   = ($urandom % 3 == 0) ? 1 + int'($urandom % 6) : -1;
            run_case(clc, blc, pk, mode == 1, p2, rk, jk, (mode == 1) ? "R6" : "R2");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule